// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block moves stereo audio between a processor and an external converter over two serial lines: one line carries data out of the port and one line carries data in. Each stereo frame holds a 16-bit left sample followed by a 16-bit right sample. Bits are sent MSB first, and the left/right clock is low while the left sample is on the line. A bit clock paces the bits. The port either generates both clocks itself (master) or follows clocks that an external device supplies (slave).

On the processor side, a single write loads a transmit holding pair (left and right together). A receive pair (left and right together) presents the last complete frame received. Interrupts come once per stereo pair, not once per sample:
- the transmit interrupt pulses when a frame begins and the held pair has been taken for sending;
- the receive interrupt pulses when a full left/right pair has arrived.

If the processor has not refilled the pair before the next frame begins, the previous pair is sent again and an underrun flag is raised for that frame.

Top module: `stereo_serial_port`

## Requirements
- R1: While reset is held, and until the first bit clock edge after reset, the port drives the following values.
  - bclk_out is 0, and lrclk_out is 1 in master mode.
  - sd_out, tx_irq, rx_irq and tx_underrun are 0.
  - rx_left and rx_right are 0.
- R2: In master mode, one bit clock period is 2*half_div system clocks, with half_div=0 treated as 1. A frame is 32 bit clocks long. lrclk_out changes only when bclk_out falls, and it is low for the first 16 bits of a frame and high for the last 16.
- R3: Each frame sends the transmit pair as 32 bits: left sample MSB first, then right sample MSB first. sd_out changes only when the bit clock falls; in master mode it changes in the same cycle as bclk_out falls.
- R4: sd_in is sampled on each rising bit clock edge. After the 32nd bit, rx_left holds the first 16 bits received and rx_right the last 16, MSB first. rx_irq pulses for one cycle in the cycle where they update, and at no other time do they change.
- R5: tx_irq pulses for exactly one cycle per frame, in the cycle where the frame's first bit is driven. It never coincides with rx_irq.
- R6: A tx_wr pulse loads tx_left/tx_right as the next pair to send. If no write happened since the previous frame start, the new frame repeats the previous pair and tx_underrun is 1 from that frame start. A frame that starts with a freshly written pair clears tx_underrun. tx_underrun changes only at frame starts.
- R7: In slave mode, bclk_in and lrclk_in pass through two synchroniser stages and are edge-detected. A frame starts on the bit clock fall at which lrclk_in has gone from 1 to 0. Transmit and receive then follow R3 and R4 on the detected edges.
- R8: In slave mode, bclk_out and lrclk_out stay at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1: port generates the clocks, 0: port follows external clocks |
| half_div | input | 8 | Half bit clock period in system clocks (master mode) |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External left/right clock (slave mode) |
| sd_in | input | 1 | Serial receive data |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| lrclk_out | output | 1 | Generated left/right clock (master mode) |
| sd_out | output | 1 | Serial transmit data |
| tx_wr | input | 1 | Write strobe for the transmit pair |
| tx_left | input | 16 | Left sample to transmit |
| tx_right | input | 16 | Right sample to transmit |
| tx_irq | output | 1 | One-cycle pulse when a frame starts and the pair is taken |
| tx_underrun | output | 1 | Current frame repeats the previous pair |
| rx_left | output | 16 | Last received left sample |
| rx_right | output | 16 | Last received right sample |
| rx_irq | output | 1 | One-cycle pulse when a new received pair is valid |

## Verification
**Master mode.** Clocks, data, interrupts and the receive pair all come from registers updated at the same system clock edge as bclk_out. So the bench polls on falling system clock edges. At the first sample that shows a new bclk_out level, tx_irq and tx_underrun must already show the frame-start values, and rx_irq, rx_left and rx_right must show the completed pair. The bench also counts system clocks between successive bit clock edges.

**Slave mode.** A detected edge lags the external edge by two synchroniser stages plus the output register, about three system clocks. The bench therefore holds each external clock phase for six system clocks. It reads sd_out, and the receive pair, only at the end of the phase that follows the edge.

// File: rtl/stereo_serial_port.sv
module stereo_serial_port #(
  parameter int SAMPLE_W = 16,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                master_mode,
  input  logic [DIV_W-1:0]    half_div,
  input  logic                bclk_in,
  input  logic                lrclk_in,
  input  logic                sd_in,
  output logic                bclk_out,
  output logic                lrclk_out,
  output logic                sd_out,
  input  logic                tx_wr,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                tx_irq,
  output logic                tx_underrun,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_irq
);
  localparam int FRAME_W = 2 * SAMPLE_W;
  localparam int POS_W   = $clog2(FRAME_W);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_W - 1);
  localparam logic [POS_W-1:0] POS_HALF = POS_W'(SAMPLE_W);

  logic [DIV_W-1:0]    div_cnt;
  logic                bclk_q;
  logic [2:0]          bclk_sync;
  logic [1:0]          lr_sync;
  logic                lr_seen;
  logic [POS_W-1:0]    pos;
  logic                synced;
  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic                tx_full;
  logic [FRAME_W-1:0]  tx_sr;
  logic [FRAME_W-2:0]  rx_sr;

  wire [DIV_W-1:0] div_last = (half_div == '0) ? '0 : half_div - 1'b1;
  wire tick        = master_mode && (div_cnt >= div_last);
  wire rise_evt    = master_mode ? (tick & ~bclk_q) : (bclk_sync[1] & ~bclk_sync[2]);
  wire fall_evt    = master_mode ? (tick &  bclk_q) : (~bclk_sync[1] & bclk_sync[2]);
  wire lr_fall     = lr_seen & ~lr_sync[1];
  wire frame_start = fall_evt & (master_mode ? (pos == POS_LAST) : lr_fall);
  wire rx_done     = rise_evt & synced & (pos == POS_LAST);
  wire [FRAME_W-1:0] rx_word = {rx_sr, sd_in};

  assign bclk_out  = master_mode & bclk_q;
  assign lrclk_out = master_mode & (pos >= POS_HALF);
  assign sd_out    = tx_sr[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      bclk_q  <= ~bclk_q;
    end else if (master_mode) begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sync <= '0;
      lr_sync   <= '0;
      lr_seen   <= 1'b0;
    end else begin
      bclk_sync <= {bclk_sync[1:0], bclk_in};
      lr_sync   <= {lr_sync[0], lrclk_in};
      if (fall_evt && !master_mode) lr_seen <= lr_sync[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= POS_LAST;
      synced <= 1'b0;
    end else if (fall_evt) begin
      pos <= (frame_start || pos == POS_LAST) ? '0 : pos + 1'b1;
      if (frame_start) synced <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l      <= '0;
      hold_r      <= '0;
      tx_full     <= 1'b0;
      tx_sr       <= '0;
      tx_underrun <= 1'b0;
      tx_irq      <= 1'b0;
    end else begin
      tx_irq <= frame_start;
      if (tx_wr) begin
        hold_l  <= tx_left;
        hold_r  <= tx_right;
        tx_full <= 1'b1;
      end else if (frame_start) begin
        tx_full <= 1'b0;
      end
      if (frame_start) begin
        tx_sr       <= {hold_l, hold_r};
        tx_underrun <= ~tx_full;
      end else if (fall_evt) begin
        tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sr    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_irq   <= 1'b0;
    end else begin
      rx_irq <= rx_done;
      if (rise_evt) rx_sr <= rx_word[FRAME_W-2:0];
      if (rx_done) begin
        rx_left  <= rx_word[FRAME_W-1:SAMPLE_W];
        rx_right <= rx_word[SAMPLE_W-1:0];
      end
    end
  end

  AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && !$stable(lrclk_out) |-> $fell(bclk_out)); // R2
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && !$stable(sd_out) |-> $fell(bclk_out)); // R3
  AST_RX_ONLY_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq |-> $stable(rx_left) && $stable(rx_right)); // R4
  AST_TX_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R5
  AST_IRQ_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_irq && rx_irq)); // R5
  AST_UNDERRUN_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_underrun) |-> tx_irq); // R6
endmodule

// File: tb/tb_stereo_serial_port.sv
module tb_stereo_serial_port;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, master_mode = 1'b1;
  logic [7:0] half_div = 8'd1;
  logic bclk_in = 1'b0, lrclk_in = 1'b1, sd_in = 1'b0, tx_wr = 1'b0;
  logic [15:0] tx_left = '0, tx_right = '0;
  logic bclk_out, lrclk_out, sd_out, tx_irq, tx_underrun, rx_irq;
  logic [15:0] rx_left, rx_right;

  stereo_serial_port dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .half_div(half_div),
    .bclk_in(bclk_in), .lrclk_in(lrclk_in), .sd_in(sd_in),
    .bclk_out(bclk_out), .lrclk_out(lrclk_out), .sd_out(sd_out),
    .tx_wr(tx_wr), .tx_left(tx_left), .tx_right(tx_right),
    .tx_irq(tx_irq), .tx_underrun(tx_underrun),
    .rx_left(rx_left), .rx_right(rx_right), .rx_irq(rx_irq));

  int n_checks = 0, n_fail = 0, n_txirq = 0, n_rxirq = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (tx_irq) n_txirq++;
    if (rx_irq) n_rxirq++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // columns: half_div, tx_left, tx_right, rx_left, rx_right
  localparam logic [71:0] VEC [4] = '{
    {8'd1, 16'hA5C3, 16'h0F0F, 16'h1234, 16'hFEDC},
    {8'd2, 16'h8001, 16'h7FFE, 16'hFFFF, 16'h0000},
    {8'd3, 16'h0000, 16'hFFFF, 16'h5555, 16'hAAAA},
    {8'd5, 16'hC0DE, 16'h3141, 16'h8000, 16'h0001}
  };

  task automatic wait_level(input logic v, inout int cyc);
    do begin
      @(negedge clk);
      tx_wr = 1'b0;
      cyc++;
    end while (bclk_out !== v);
  endtask

  task automatic do_reset(input bit m, input logic [7:0] hd, input logic [31:0] txp);
    @(negedge clk);
    rst_n = 1'b0; master_mode = m; half_div = hd;
    sd_in = 1'b0; bclk_in = 1'b0; lrclk_in = 1'b1; tx_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; tx_wr = 1'b1; {tx_left, tx_right} = txp;
  endtask

  task automatic m_frame(input logic [31:0] exp_tx, input bit exp_und, input logic [31:0] rxpat,
                         input int wr_at, input logic [31:0] wr_pair, input int per);
    logic [31:0] got = '0;
    bit lr_bad = 1'b0, per_bad = 1'b0;
    int first_per = 0;
    int tx0 = n_txirq;
    for (int i = 0; i < 32; i++) begin
      int cyc = 0;
      wait_level(1'b0, cyc);
      if (i == 0) begin
        check(tx_irq === 1'b1, "R5 tx_irq at frame start", {31'd0, tx_irq}, 32'd1);
        check(tx_underrun === exp_und, "R6 underrun flag", {31'd0, tx_underrun}, {31'd0, exp_und});
      end
      if (lrclk_out !== (i >= 16)) lr_bad = 1'b1;
      if (i == wr_at) begin
        tx_wr = 1'b1; {tx_left, tx_right} = wr_pair;
      end
      sd_in = rxpat[31-i];
      wait_level(1'b1, cyc);
      if (cyc != per) begin
        per_bad = 1'b1; first_per = cyc;
      end
      got[31-i] = sd_out;
      if (i == 31) begin
        check(rx_irq === 1'b1, "R4 rx_irq after last bit", {31'd0, rx_irq}, 32'd1);
        check({rx_left, rx_right} === rxpat, "R4 received pair", {rx_left, rx_right}, rxpat);
      end
    end
    check(got === exp_tx, "R3 serial transmit data", got, exp_tx);
    check(!lr_bad, "R2 lrclk low for left half", {31'd0, lr_bad}, 32'd0);
    check(!per_bad, "R2 bit clock period", first_per, per);
    check(n_txirq - tx0 == 1, "R5 one tx_irq per frame", n_txirq - tx0, 1);
  endtask

  task automatic s_bit(input logic lr, input logic d, output logic q, inout bit outs_bad);
    bclk_in = 1'b0; lrclk_in = lr; sd_in = d;
    repeat (6) @(negedge clk);
    q = sd_out;
    if (bclk_out !== 1'b0 || lrclk_out !== 1'b0) outs_bad = 1'b1;
    tx_wr = 1'b0;
    bclk_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic s_frame(input logic [31:0] exp_tx, input bit exp_und, input logic [31:0] rxpat);
    logic [31:0] got = '0;
    bit ob = 1'b0;
    int rx0 = n_rxirq;
    int tx0 = n_txirq;
    for (int i = 0; i < 32; i++) begin
      logic q;
      s_bit(i >= 16, rxpat[31-i], q, ob);
      got[31-i] = q;
    end
    check(got === exp_tx, "R7 slave transmit data", got, exp_tx);
    check({rx_left, rx_right} === rxpat, "R7 slave received pair", {rx_left, rx_right}, rxpat);
    check(n_rxirq - rx0 == 1, "R7 one rx_irq per slave frame", n_rxirq - rx0, 1);
    check(n_txirq - tx0 == 1, "R7 one tx_irq per slave frame", n_txirq - tx0, 1);
    check(tx_underrun === exp_und, "R6 slave underrun flag", {31'd0, tx_underrun}, {31'd0, exp_und});
    check(!ob, "R8 slave clock outputs low", {31'd0, ob}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state in master mode
    check(bclk_out === 1'b0 && lrclk_out === 1'b1 && sd_out === 1'b0, "R1 reset clocks/data",
          {29'd0, bclk_out, lrclk_out, sd_out}, 32'h2);
    check(tx_irq === 1'b0 && rx_irq === 1'b0 && tx_underrun === 1'b0, "R1 reset flags",
          {29'd0, tx_irq, rx_irq, tx_underrun}, 32'h0);
    check({rx_left, rx_right} === 32'h0, "R1 reset rx pair", {rx_left, rx_right}, 32'h0);

    for (int v = 0; v < 4; v++) begin
      logic [7:0]  hd  = VEC[v][71:64];
      logic [31:0] txp = VEC[v][63:32];
      logic [31:0] rxp = VEC[v][31:0];
      int c = 0;
      do_reset(1'b1, hd, txp);
      wait_level(1'b1, c);
      m_frame(txp, 1'b0, rxp, -1, 32'h0, 2 * hd);
      m_frame(txp, 1'b1, {rxp[15:0], rxp[31:16]}, 8, ~txp, 2 * hd);
      m_frame(~txp, 1'b0, ~rxp, -1, 32'h0, 2 * hd);
    end

    begin
      int c = 0;
      do_reset(1'b1, 8'd0, 32'h6B2D_91E4);
      wait_level(1'b1, c);
      m_frame(32'h6B2D_91E4, 1'b0, 32'h0F1E_2D3C, -1, 32'h0, 2); // R2 half_div=0 acts as 1
    end

    begin
      bit ob = 1'b0;
      logic q;
      do_reset(1'b0, 8'd1, 32'hBEEF_1357);
      @(negedge clk);
      tx_wr = 1'b0;
      check(bclk_out === 1'b0 && lrclk_out === 1'b0, "R8 slave outputs after reset",
            {30'd0, bclk_out, lrclk_out}, 32'h0);
      s_bit(1'b1, 1'b0, q, ob);
      s_bit(1'b1, 1'b0, q, ob);
      s_frame(32'hBEEF_1357, 1'b0, 32'hCAFE_0042);
      s_frame(32'hBEEF_1357, 1'b1, 32'h7001_E00F);
    end

    finish_up();
  end
endmodule